// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the register file of a four-channel DMA controller. One bus port reads and writes it, and every access carries a tag that names its initiator. The initiator is either the CPU or one of the DMA channels, which writes as part of a transfer. Each channel has four 32-bit words: control, source address, destination address and transfer count. One shared word after the channel words holds a pending-interrupt bit for each channel.

The bank decides which writes take effect. That decision depends on the target channel's enable bit and on whether the writer is the CPU, another channel or the target channel itself. A write that a channel issues to its own registers is discarded and reported on a one-cycle error output. The request flag and the interrupt bits can only be set by hardware event inputs. A written 0 clears them and a written 1 leaves them as they are. Every register value is also driven continuously onto flat output buses for the transfer engine.

Word map: channel n occupies word addresses 4n (control), 4n+1 (source), 4n+2 (destination) and 4n+3 (count). Word 16 is the interrupt word. Words 17 to 31 read as zero and ignore writes. In the control word, bit 0 is the enable bit and bit 1 is the request flag. Bits 31 to 2 are mode bits that the bank stores without interpreting them.

Top module: `dma_reg_bank`

## Requirements
- R1: After synchronous reset, every register is zero. All engine outputs, `bus_rdata` and `self_wr_err` are zero, so every channel is disabled.
- R2: A write to a channel's count word (4n+3) is ignored while that channel's enable bit (control bit 0) is 1, whoever issues it. The write is accepted while the enable bit is 0.
- R3: Control bit 0 takes the written value on every accepted control write, whether the channel is enabled or not.
- R4: Control bit 1 becomes 0 when a control write carries 0 in bit 1. It is unchanged when the write carries 1. A pulse on `hw_req[n]` sets it in the next cycle, and it is set even when a clearing write arrives in the same cycle.
- R5: Bit n of word 16 is the interrupt bit of channel n, and bits 31 to 4 read as 0. Writing 0 to a bit clears it and writing 1 keeps it. A pulse on `hw_done[n]` sets bit n, and the set wins over a clear in the same cycle.
- R6: While a channel is enabled, a CPU write (`bus_is_dma`=0) to its source or destination word leaves that word unchanged, and a CPU write to its control word leaves control bits 31 to 2 unchanged. While the channel is disabled, these writes take effect.
- R7: A DMA write (`bus_is_dma`=1) from channel k to the source or destination word of a different channel j takes effect even while channel j is enabled.
- R8: A DMA write from channel k to any of words 4k to 4k+3 changes nothing. It drives `self_wr_err` high for exactly the one cycle after that access, and `self_wr_err` is low at all other times.
- R9: A read (`bus_en`=1, `bus_we`=0) loads `bus_rdata` on the next clock edge with the value the addressed word held before that edge. Unmapped words return 0, and `bus_rdata` holds its value when no read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_is_dma | input | 1 | Access issued by a DMA channel rather than the CPU |
| bus_chan | input | 2 | Issuing channel when bus_is_dma is 1 |
| bus_rdata | output | 32 | Registered read data |
| self_wr_err | output | 1 | One-cycle pulse after a discarded self-write |
| hw_req | input | 4 | Per-channel request event pulses |
| hw_done | input | 4 | Per-channel count-reached-zero pulses |
| ctrl_o | output | 128 | Control words, channel n at bits 32n+31:32n |
| src_o | output | 128 | Source addresses, packed the same way |
| dst_o | output | 128 | Destination addresses, packed the same way |
| cnt_o | output | 128 | Transfer counts, packed the same way |
| irq_o | output | 4 | Pending-interrupt bits |

## Verification
Every register drives an output bus continuously. A write that lands wrongly therefore shows on `ctrl_o`, `src_o`, `dst_o`, `cnt_o` or `irq_o` in the cycle right after the access, and the bench compares all of them against its model after every edge. Faults hidden by the protection rules are the main target. Examples are a count that moves while its channel is enabled, a request flag that software sets, and a peer write that is refused. These are driven both in directed sequences and in many random cycles with all three kinds of initiator. The registered read path and the error pulse are checked in the same cycle, so a wrong read mux or a late or missing error shows up at the first access that exposes it.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_SRC  = 2'd1;
  localparam logic [1:0] OFS_DST  = 2'd2;
  localparam logic [1:0] OFS_CNT  = 2'd3;
  localparam int EN_BIT  = 0;
  localparam int REQ_BIT = 1;
  localparam int WORDS_PER_CH = 4;
endpackage

// File: rtl/dma_bank_decode.sv
module dma_bank_decode #(
  parameter int NCH = 4,
  parameter int AW  = 5,
  parameter int CW  = 2
) (
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_is_dma,
  input  logic [CW-1:0]  bus_chan,
  output logic [NCH-1:0] ch_wr,
  output logic           irq_wr,
  output logic           self_wr
);
  localparam int RW = AW - 2;
  localparam int CH_WORDS = NCH * dma_bank_pkg::WORDS_PER_CH;

  logic          wr;
  logic          in_chan;
  logic [RW-1:0] region;

  assign wr      = bus_en && bus_we;
  assign in_chan = (int'(bus_addr) < CH_WORDS);
  assign region  = bus_addr[AW-1:2];
  assign self_wr = wr && in_chan && bus_is_dma && (region == RW'(bus_chan));
  assign irq_wr  = wr && (int'(bus_addr) == CH_WORDS);

  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign ch_wr[n] = wr && in_chan && !self_wr && (region == RW'(n));
  end
endmodule

// File: rtl/dma_bank_chan.sv
module dma_bank_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    ofs,
  input  logic          from_peer,
  input  logic [DW-1:0] wdata,
  input  logic          hw_req,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] src,
  output logic [DW-1:0] dst,
  output logic [DW-1:0] cnt
);
  import dma_bank_pkg::*;

  logic          en;
  logic          addr_ok;
  logic [DW-1:0] ctrl_next;

  assign en      = ctrl[EN_BIT];
  assign addr_ok = !en || from_peer;

  always_comb begin
    ctrl_next = ctrl;
    if (wr && ofs == OFS_CTRL) begin
      ctrl_next[EN_BIT]  = wdata[EN_BIT];
      ctrl_next[REQ_BIT] = ctrl[REQ_BIT] & wdata[REQ_BIT];
      if (!en) ctrl_next[DW-1:2] = wdata[DW-1:2];
    end
    if (hw_req) ctrl_next[REQ_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
    end else begin
      ctrl <= ctrl_next;
      if (wr && ofs == OFS_SRC && addr_ok) src <= wdata;
      if (wr && ofs == OFS_DST && addr_ok) dst <= wdata;
      if (wr && ofs == OFS_CNT && !en)     cnt <= wdata;
    end
  end
endmodule

// File: rtl/dma_bank_irq.sv
module dma_bank_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [NCH-1:0] keep_mask,
  input  logic [NCH-1:0] hw_done,
  output logic [NCH-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (wr ? (stat & keep_mask) : stat) | hw_done;
  end
endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int AW = $clog2(NCH * 4 + 1),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_is_dma,
  input  logic [CW-1:0]    bus_chan,
  output logic [DW-1:0]    bus_rdata,
  output logic             self_wr_err,
  input  logic [NCH-1:0]   hw_req,
  input  logic [NCH-1:0]   hw_done,
  output logic [NCH*DW-1:0] ctrl_o,
  output logic [NCH*DW-1:0] src_o,
  output logic [NCH*DW-1:0] dst_o,
  output logic [NCH*DW-1:0] cnt_o,
  output logic [NCH-1:0]   irq_o
);
  import dma_bank_pkg::*;

  localparam int RW = AW - 2;
  localparam int CH_WORDS = NCH * WORDS_PER_CH;

  logic [NCH-1:0] ch_wr;
  logic           irq_wr;
  logic           self_wr;
  logic [DW-1:0]  rd_next;

  dma_bank_decode #(.NCH(NCH), .AW(AW), .CW(CW)) u_dec (
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_is_dma (bus_is_dma),
    .bus_chan   (bus_chan),
    .ch_wr      (ch_wr),
    .irq_wr     (irq_wr),
    .self_wr    (self_wr)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dma_bank_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr        (ch_wr[n]),
      .ofs       (bus_addr[1:0]),
      .from_peer (bus_is_dma),
      .wdata     (bus_wdata),
      .hw_req    (hw_req[n]),
      .ctrl      (ctrl_o[n*DW +: DW]),
      .src       (src_o[n*DW +: DW]),
      .dst       (dst_o[n*DW +: DW]),
      .cnt       (cnt_o[n*DW +: DW])
    );
  end

  dma_bank_irq #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .wr        (irq_wr),
    .keep_mask (bus_wdata[NCH-1:0]),
    .hw_done   (hw_done),
    .stat      (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (int'(bus_addr) == CH_WORDS) rd_next[NCH-1:0] = irq_o;
    for (int n = 0; n < NCH; n++) begin
      if (int'(bus_addr) < CH_WORDS && bus_addr[AW-1:2] == RW'(n)) begin
        case (bus_addr[1:0])
          OFS_CTRL: rd_next = ctrl_o[n*DW +: DW];
          OFS_SRC:  rd_next = src_o[n*DW +: DW];
          OFS_DST:  rd_next = dst_o[n*DW +: DW];
          default:  rd_next = cnt_o[n*DW +: DW];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      self_wr_err <= 1'b0;
    end else begin
      self_wr_err <= self_wr;
      if (bus_en && !bus_we) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/dma_bank_chk.sv
module dma_bank_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int AW = $clog2(NCH * 4 + 1),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_is_dma,
  input logic [CW-1:0]     bus_chan,
  input logic              self_wr_err,
  input logic [NCH-1:0]    hw_req,
  input logic [NCH-1:0]    hw_done,
  input logic [NCH*DW-1:0] ctrl_o,
  input logic [NCH*DW-1:0] src_o,
  input logic [NCH*DW-1:0] cnt_o,
  input logic [NCH-1:0]    irq_o
);
  logic self_acc;
  assign self_acc = bus_en && bus_we && bus_is_dma && (int'(bus_addr) < NCH * 4)
                    && ((int'(bus_addr) / 4) == int'(bus_chan));

  AST_SELF_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    self_acc |=> self_wr_err); // R8
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    self_wr_err |-> $past(self_acc)); // R8

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic wr_src;
    assign wr_src = bus_en && bus_we && (int'(bus_addr) == n * 4 + 1);

    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
      ctrl_o[n*DW] |=> $stable(cnt_o[n*DW +: DW])); // R2
    AST_REQ_HW_ONLY: assert property (@(posedge clk) disable iff (rst)
      $rose(ctrl_o[n*DW+1]) |-> $past(hw_req[n])); // R4
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
      hw_done[n] |=> irq_o[n]); // R5
    AST_CPU_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
      (ctrl_o[n*DW] && wr_src && !bus_is_dma) |=> $stable(src_o[n*DW +: DW])); // R6
    AST_PEER_SRC_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (wr_src && bus_is_dma && int'(bus_chan) != n)
      |=> (src_o[n*DW +: DW] == $past(bus_wdata))); // R7
  end
endmodule

bind dma_reg_bank dma_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_is_dma  (bus_is_dma),
  .bus_chan    (bus_chan),
  .self_wr_err (self_wr_err),
  .hw_req      (hw_req),
  .hw_done     (hw_done),
  .ctrl_o      (ctrl_o),
  .src_o       (src_o),
  .cnt_o       (cnt_o),
  .irq_o       (irq_o)
);

// File: tb/tb_dma_reg_bank.sv
`timescale 1ns/1ps
module tb_dma_reg_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_en = 0, bus_we = 0, bus_is_dma = 0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [1:0]   bus_chan = '0;
  logic [31:0]  bus_rdata;
  logic         self_wr_err;
  logic [3:0]   hw_req = '0, hw_done = '0;
  logic [127:0] ctrl_o, src_o, dst_o, cnt_o;
  logic [3:0]   irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl [4];
  logic [31:0] m_src  [4];
  logic [31:0] m_dst  [4];
  logic [31:0] m_cnt  [4];
  logic [3:0]  m_irq;
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  dma_reg_bank dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_is_dma(bus_is_dma), .bus_chan(bus_chan),
    .bus_rdata(bus_rdata), .self_wr_err(self_wr_err), .hw_req(hw_req),
    .hw_done(hw_done), .ctrl_o(ctrl_o), .src_o(src_o), .dst_o(dst_o),
    .cnt_o(cnt_o), .irq_o(irq_o)
  );

  function automatic logic [127:0] pack4(input logic [31:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] a);
    if (a < 16) begin
      case (a[1:0])
        2'd0: return m_ctrl[a[4:2]];
        2'd1: return m_src[a[4:2]];
        2'd2: return m_dst[a[4:2]];
        default: return m_cnt[a[4:2]];
      endcase
    end
    if (a == 16) return {28'd0, m_irq};
    return 32'd0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic en, we, input logic [4:0] a, input logic [31:0] d,
                     input logic dma, input logic [1:0] ch,
                     input logic [3:0] hr, hd, input string tag);
    logic exp_err;
    int n;
    logic enb;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    bus_is_dma = dma; bus_chan = ch; hw_req = hr; hw_done = hd;
    exp_err = en && we && dma && (a < 16) && (a[4:2] == {1'b0, ch});
    if (en && !we) m_rd = model_read(a);
    if (en && we && !exp_err) begin
      if (a < 16) begin
        n = int'(a[4:2]);
        enb = m_ctrl[n][0];
        case (a[1:0])
          2'd0: m_ctrl[n] = {enb ? m_ctrl[n][31:2] : d[31:2], m_ctrl[n][1] & d[1], d[0]};
          2'd1: if (!enb || dma) m_src[n] = d;
          2'd2: if (!enb || dma) m_dst[n] = d;
          default: if (!enb) m_cnt[n] = d;
        endcase
      end else if (a == 16) begin
        m_irq = m_irq & d[3:0];
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (hr[k]) m_ctrl[k][1] = 1'b1;
      if (hd[k]) m_irq[k] = 1'b1;
    end
    @(posedge clk);
    #1;
    check(tag, "ctrl_o", ctrl_o, pack4(m_ctrl[0], m_ctrl[1], m_ctrl[2], m_ctrl[3]));
    check(tag, "src_o",  src_o,  pack4(m_src[0], m_src[1], m_src[2], m_src[3]));
    check(tag, "dst_o",  dst_o,  pack4(m_dst[0], m_dst[1], m_dst[2], m_dst[3]));
    check(tag, "cnt_o",  cnt_o,  pack4(m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]));
    check(tag, "irq_o",  {124'd0, irq_o}, {124'd0, m_irq});
    check(tag, "self_wr_err", {127'd0, self_wr_err}, {127'd0, exp_err});
    check(tag, "bus_rdata", {96'd0, bus_rdata}, {96'd0, m_rd});
  endtask

  task automatic cpu_wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, d, 0, 2'd0, 4'd0, 4'd0, tag);
  endtask
  task automatic dma_wr(input logic [1:0] ch, input logic [4:0] a, input logic [31:0] d,
                        input string tag);
    cyc(1, 1, a, d, 1, ch, 4'd0, 4'd0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    cyc(1, 0, a, 32'd0, 0, 2'd0, 4'd0, 4'd0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 5'd0, 32'd0, 0, 2'd0, 4'd0, 4'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_ctrl[k] = 0; m_src[k] = 0; m_dst[k] = 0; m_cnt[k] = 0;
    end
    m_irq = 0; m_rd = 0;
    void'($urandom(32'hC0FFEE11));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R1", "ctrl_o", ctrl_o, 128'd0);
    check("R1", "cnt_o", cnt_o, 128'd0);
    check("R1", "bus_rdata", {96'd0, bus_rdata}, 128'd0);
    idle("R1");
    rd(5'd3, "R1");
    rd(5'd16, "R1");

    // R9: unmapped word
    cpu_wr(5'd17, 32'hFFFF_FFFF, "R9");
    rd(5'd17, "R9");

    // R2 and R6 while disabled, then enabled
    cpu_wr(5'd7, 32'h0000_0100, "R2");
    cpu_wr(5'd5, 32'h1000_0000, "R6");
    cpu_wr(5'd4, 32'hA5A5_A5A1, "R3");
    cpu_wr(5'd7, 32'h0000_0222, "R2");
    dma_wr(2'd0, 5'd7, 32'h0000_0333, "R2");
    cpu_wr(5'd5, 32'h2000_0000, "R6");
    cpu_wr(5'd6, 32'h3000_0000, "R6");
    cpu_wr(5'd4, 32'h0000_0FFD, "R6");
    rd(5'd4, "R9");
    // R7: peer writes while ch1 enabled
    dma_wr(2'd0, 5'd5, 32'h4444_0000, "R7");
    dma_wr(2'd3, 5'd6, 32'h5555_0000, "R7");
    rd(5'd5, "R9");
    // R3: disable, then counts writable again
    cpu_wr(5'd4, 32'h0000_0000, "R3");
    cpu_wr(5'd7, 32'h0000_0444, "R2");
    cpu_wr(5'd5, 32'h6666_0000, "R6");

    // R8: self writes
    dma_wr(2'd2, 5'd10, 32'hDEAD_BEEF, "R8");
    idle("R8");
    dma_wr(2'd2, 5'd8, 32'h0000_0001, "R8");
    dma_wr(2'd3, 5'd15, 32'h0000_0777, "R8");
    dma_wr(2'd3, 5'd10, 32'h0000_0888, "R8");
    idle("R8");

    // R4: request flag
    cyc(0, 0, 5'd0, 0, 0, 0, 4'b1000, 4'd0, "R4");
    cpu_wr(5'd12, 32'h0000_0002, "R4");
    cyc(1, 1, 5'd12, 32'h0, 0, 0, 4'b1000, 4'd0, "R4");
    cpu_wr(5'd12, 32'h0000_0000, "R4");
    cpu_wr(5'd12, 32'h0000_0002, "R4");
    rd(5'd12, "R4");

    // R5: interrupt word
    cyc(0, 0, 5'd0, 0, 0, 0, 4'd0, 4'b0101, "R5");
    cpu_wr(5'd16, 32'hFFFF_FFFE, "R5");
    cyc(1, 1, 5'd16, 32'h0, 0, 0, 4'd0, 4'b0100, "R5");
    rd(5'd16, "R5");
    cpu_wr(5'd16, 32'h0000_0000, "R5");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      a = 5'($urandom_range(0, 18));
      d = $urandom;
      if (($urandom & 3) == 0) d[0] = 1'b1;
      cyc(($urandom & 7) != 0, ($urandom & 3) != 0, a, d, $urandom & 1,
          2'($urandom), 4'($urandom & $urandom & $urandom),
          4'($urandom & $urandom & $urandom), "RAND");
    end
    for (int w = 0; w < 17; w++) rd(5'(w), "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule